// File: doc/BRIEF.md
# Masked External Interrupt Aggregator

This block gathers a set of external interrupt request lines, 32 by default, and merges them into a single interrupt output for a parent interrupt controller. Each request line may be asynchronous to the block clock. It passes through a two-stage synchronizer. The block then latches the request into a per-source pending bit, which holds until software clears it. The output is high whenever any pending source is also enabled by its mask bit. A mask bit of 1 blocks its source.

Software reaches the block over a small 32-bit register bus with select, write enable, address, write data and combinational read data. The bus has three word registers. The first is a readable clear control at offset 0x10. The second is a mask at offset 0x14. The third is a read-only pending status word at offset 0x1C. A service routine reads the status word and handles sources from bit 0 upward. For each source it sets that source's clear bit and then writes the bit back to 0. The clear acts as a held level, not a one-shot pulse. While the clear bit is 1, the source cannot become pending. A request line that is still high once the clear bit drops becomes pending again on the next clock.

The external reset is asynchronous and active low. The block asserts it at once and releases it through a two-flop reset synchronizer.

Top module: `irq_aggregator`

## Requirements
- R1: Two clock edges after reset release, the mask register reads 0xFFFFFFFF, the clear register reads 0, the status word reads 0 and `irq_o` is 0.
- R2: A bus write to offset 0x14 loads the mask register, and a read of 0x14 returns the written value. Bit i belongs to source i.
- R3: A bus write to offset 0x10 loads the clear register, and a read of 0x10 returns the written value. Bit i belongs to source i.
- R4: A read of offset 0x1C returns the pending bits, with bit i set when source i is pending. Once set, a pending bit stays set after its request line drops, until its clear bit is 1.
- R5: While clear bit i is 1, pending bit i reads 0, even when request line i is high.
- R6: When clear bit i returns to 0 while request line i is still high, pending bit i reads 1 exactly one clock edge after the edge that wrote the clear bit low.
- R7: `irq_o` is 1 one clock edge after some pending bit has its mask bit at 0. It is 0 one edge after every pending bit is masked or no bit is pending. A mask bit of 1 blocks its source.
- R8: Reads of any offset other than 0x10, 0x14 and 0x1C return 0. Writes to offset 0x1C, or to any unmapped offset, change no register.
- R9: A request line that rises just after clock edge 0 is not yet visible in the status word after edge 2. It is visible after edge 3, and it drives `irq_o` high after edge 4 when unmasked.
- R10: Several sources may be pending at the same time, and all of them appear together in the status word. Clearing one source leaves the other pending bits untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_src_i | input | NUM_SRC | Level interrupt request lines, may be asynchronous |
| bus_sel_i | input | 1 | Register bus select |
| bus_write_i | input | 1 | Register bus write enable (1 write, 0 read) |
| bus_addr_i | input | ADDR_W | Register bus byte address |
| bus_wdata_i | input | DATA_W | Register bus write data |
| bus_rdata_o | output | DATA_W | Register bus read data, zero when no read is selected |
| irq_o | output | 1 | Aggregated interrupt to the parent controller |

## Verification
The assertions assume that every bus access lasts exactly one cycle with select high, and that the address is stable while it is selected. They also assume that request lines, once sampled through the synchronizer, obey ordinary level semantics: a line can rise or fall at any cycle. The assertions make no claim about how long a line stays high. The bench drives all bus and request inputs on the falling clock edge, so each access falls inside a single rising edge. It reads the combinational read data one nanosecond after setting the address, inside the same low phase, so a read never spans a rising edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Byte offsets of the three word registers
  localparam int unsigned OFF_CLEAR  = 32'h10;
  localparam int unsigned OFF_MASK   = 32'h14;
  localparam int unsigned OFF_STATUS = 32'h1C;

  // Register decode result
  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_CLEAR  = 2'd1,
    REG_MASK   = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_agg_rst_sync.sv
module irq_agg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Shift ones in after release; assert is immediate through the async path
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[LAST];

endmodule

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < int'(STAGES); s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_o = stage_q[LAST];

endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] clr_o
);

  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFF_CLEAR);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

  reg_sel_e           reg_sel;
  logic               wr_act;
  logic               rd_act;
  logic               mask_en;
  logic               clr_en;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_d;
  logic [NUM_SRC-1:0] clr_q;
  logic [NUM_SRC-1:0] clr_d;
  logic [DATA_W-1:0]  rdata;

  // Address decode
  always_comb begin
    unique case (bus_addr_i)
      A_CLEAR:  reg_sel = REG_CLEAR;
      A_MASK:   reg_sel = REG_MASK;
      A_STATUS: reg_sel = REG_STATUS;
      default:  reg_sel = REG_NONE;
    endcase
  end

  assign wr_act = bus_sel_i &  bus_write_i;
  assign rd_act = bus_sel_i & ~bus_write_i;

  // Next state and clock enables
  always_comb begin
    mask_en = wr_act && (reg_sel == REG_MASK);
    clr_en  = wr_act && (reg_sel == REG_CLEAR);
    mask_d  = bus_wdata_i[NUM_SRC-1:0];
    clr_d   = bus_wdata_i[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= '0;
    end else if (clr_en) begin
      clr_q <= clr_d;
    end
  end

  // Read mux, zero-extended, zero for unmapped offsets
  always_comb begin
    rdata = '0;
    if (rd_act) begin
      unique case (reg_sel)
        REG_CLEAR:  rdata = DATA_W'(clr_q);
        REG_MASK:   rdata = DATA_W'(mask_q);
        REG_STATUS: rdata = DATA_W'(pend_i);
        default:    rdata = '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata;
  assign mask_o      = mask_q;
  assign clr_o       = clr_q;

  // R2: a mask write lands exactly the written bits
  p_mask_write_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_write_i && bus_addr_i == A_MASK)
      |=> (mask_q == $past(bus_wdata_i[NUM_SRC-1:0])));

  // R3: a clear write lands exactly the written bits
  p_clear_write_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_write_i && bus_addr_i == A_CLEAR)
      |=> (clr_q == $past(bus_wdata_i[NUM_SRC-1:0])));

  // R8: writing the status offset changes neither control register
  p_status_write_ignored_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_write_i && bus_addr_i == A_STATUS)
      |=> ($stable(mask_q) && $stable(clr_q)));

endmodule

// File: rtl/irq_agg_pending.sv
module irq_agg_pending #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_d;
  logic               irq_q;
  logic               irq_d;

  // Per-source capture: held clear wins over a live request
  for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_src
    assign pend_d[i] = ~clr_i[i] & (pend_q[i] | src_i[i]);
  end

  assign irq_d = |(pend_q & ~mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R5: a source whose clear bit was high cannot be pending afterwards
  p_clear_blocks_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((pend_q & $past(clr_i)) == '0));

  // R4: pending bits never drop unless their clear bit was high
  p_sticky_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |=> (($past(pend_q) & ~$past(clr_i) & ~pend_q) == '0));

  // R4: a pending bit only rises when its synchronized request was high
  p_set_needs_src_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(src_i)) == '0));

  // R7: with every source masked the output is low one edge later
  p_all_masked_quiet_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '1) |=> !irq_q);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               bus_sel_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);

  logic               rst_n;
  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] clr;

  irq_agg_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  irq_agg_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (irq_src_i),
    .sync_o  (src_sync)
  );

  irq_agg_regs #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .pend_i      (pend),
    .bus_rdata_o (bus_rdata_o),
    .mask_o      (mask),
    .clr_o       (clr)
  );

  irq_agg_pending #(
    .NUM_SRC (NUM_SRC)
  ) u_pending (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_sync),
    .clr_i  (clr),
    .mask_i (mask),
    .pend_o (pend),
    .irq_o  (irq_o)
  );

endmodule

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;

  logic        clk;
  logic        arst_n;
  logic [31:0] irq_src;
  logic        bus_sel;
  logic        bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;

  localparam logic [7:0] A_CLR  = 8'h10;
  localparam logic [7:0] A_MSK  = 8'h14;
  localparam logic [7:0] A_STS  = 8'h1C;

  irq_aggregator u_irq_aggregator (
    .clk         (clk),
    .arst_n      (arst_n),
    .irq_src_i   (irq_src),
    .bus_sel_i   (bus_sel),
    .bus_write_i (bus_write),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // One-cycle write straddling a single rising edge; returns at the next falling edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  // Combinational read inside the current low phase
  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0; bus_addr = '0;
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset_r1;
    logic [31:0] v;
    @(negedge clk);
    bus_rd(A_MSK, v); check("R1 mask after reset", v, 32'hFFFF_FFFF);
    bus_rd(A_CLR, v); check("R1 clear after reset", v, 32'h0);
    bus_rd(A_STS, v); check("R1 status after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs_r2_r3;
    logic [31:0] v;
    bus_wr(A_MSK, 32'hA5A5_0F0F);
    bus_rd(A_MSK, v); check("R2 mask readback", v, 32'hA5A5_0F0F);
    bus_wr(A_CLR, 32'h1234_8001);
    bus_rd(A_CLR, v); check("R3 clear readback", v, 32'h1234_8001);
    bus_wr(A_CLR, 32'h0);
    bus_rd(A_CLR, v); check("R3 clear back to zero", v, 32'h0);
    bus_wr(A_MSK, 32'hFFFF_FFFF);
  endtask

  task automatic t_latency_r9;
    logic [31:0] v;
    bus_wr(A_MSK, 32'hFFFF_FFDF);       // unmask source 5
    @(negedge clk);
    irq_src[5] = 1'b1;                  // rises before edge 1
    wait_neg(2);                        // after edge 2
    bus_rd(A_STS, v); check("R9 not visible after edge 2", v, 32'h0);
    wait_neg(1);                        // after edge 3
    bus_rd(A_STS, v); check("R9 visible after edge 3", v, 32'h0000_0020);
    check("R9 irq still low after edge 3", {31'b0, irq}, 32'h0);
    wait_neg(1);                        // after edge 4
    check("R9 irq high after edge 4", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_clear_r5_r6;
    logic [31:0] v;
    // source 5 still high and pending here
    bus_wr(A_CLR, 32'h0000_0020);       // clear register set at edge W
    wait_neg(1);                        // pending dropped at W+1
    bus_rd(A_STS, v); check("R5 pending low while clear held", v, 32'h0);
    wait_neg(3);
    bus_rd(A_STS, v); check("R5 still low with request high", v, 32'h0);
    check("R5 irq low while clear held", {31'b0, irq}, 32'h0);
    bus_wr(A_CLR, 32'h0);               // clear low at edge W
    bus_rd(A_STS, v); check("R6 not pending at edge W", v, 32'h0);
    wait_neg(1);
    bus_rd(A_STS, v); check("R6 re-pending one edge later", v, 32'h0000_0020);
  endtask

  task automatic t_sticky_r4;
    logic [31:0] v;
    irq_src[5] = 1'b0;
    wait_neg(5);
    bus_rd(A_STS, v); check("R4 pending held after request drops", v, 32'h0000_0020);
    bus_wr(A_CLR, 32'h0000_0020);
    bus_wr(A_CLR, 32'h0);
    wait_neg(2);
    bus_rd(A_STS, v); check("R4 pending gone after clear", v, 32'h0);
  endtask

  task automatic t_mask_r7;
    logic [31:0] v;
    bus_wr(A_MSK, 32'hFFFF_FFFF);
    irq_src[31] = 1'b1;
    wait_neg(3);
    irq_src[31] = 1'b0;
    wait_neg(2);
    bus_rd(A_STS, v); check("R7 source 31 pending", v, 32'h8000_0000);
    check("R7 masked source keeps irq low", {31'b0, irq}, 32'h0);
    bus_wr(A_MSK, 32'h7FFF_FFFF);       // mask updates at W
    wait_neg(1);                        // irq after W+1
    check("R7 unmasked pending raises irq", {31'b0, irq}, 32'h1);
    bus_wr(A_MSK, 32'hFFFF_FFFF);
    wait_neg(1);
    check("R7 re-masking drops irq", {31'b0, irq}, 32'h0);
    bus_wr(A_CLR, 32'h8000_0000);
    bus_wr(A_CLR, 32'h0);
  endtask

  task automatic t_multi_r10;
    logic [31:0] v;
    irq_src[0] = 1'b1; irq_src[3] = 1'b1; irq_src[31] = 1'b1;
    wait_neg(4);
    irq_src = '0;
    wait_neg(3);
    bus_rd(A_STS, v); check("R10 all pending together", v, 32'h8000_0009);
    bus_wr(A_CLR, 32'h0000_0008);
    bus_wr(A_CLR, 32'h0);
    wait_neg(1);
    bus_rd(A_STS, v); check("R10 others untouched by clear", v, 32'h8000_0001);
    bus_wr(A_CLR, 32'h8000_0001);
    bus_wr(A_CLR, 32'h0);
    wait_neg(1);
    bus_rd(A_STS, v); check("R10 remaining cleared", v, 32'h0);
  endtask

  task automatic t_unmapped_r8;
    logic [31:0] v;
    bus_wr(A_MSK, 32'h0F0F_F0F0);
    bus_wr(A_CLR, 32'h0000_0000);
    @(negedge clk);
    bus_rd(8'h00, v); check("R8 read 0x00", v, 32'h0);
    bus_rd(8'h18, v); check("R8 read 0x18", v, 32'h0);
    bus_rd(8'h15, v); check("R8 read 0x15", v, 32'h0);
    bus_rd(8'h20, v); check("R8 read 0x20", v, 32'h0);
    bus_wr(A_STS, 32'hFFFF_FFFF);
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_wr(8'h11, 32'hFFFF_FFFF);
    bus_wr(8'h00, 32'h0);
    wait_neg(1);
    bus_rd(A_STS, v); check("R8 status unchanged by writes", v, 32'h0);
    bus_rd(A_MSK, v); check("R8 mask unchanged by stray writes", v, 32'h0F0F_F0F0);
    bus_rd(A_CLR, v); check("R8 clear unchanged by stray writes", v, 32'h0);
    check("R8 irq unchanged", {31'b0, irq}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    arst_n    = 1'b0;
    irq_src   = '0;
    bus_sel   = 1'b0;
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    wait_neg(4);
    arst_n = 1'b1;
    wait_neg(3);
    t_reset_r1();
    t_regs_r2_r3();
    t_latency_r9();
    t_clear_r5_r6();
    t_sticky_r4();
    t_mask_r7();
    t_multi_r10();
    t_unmapped_r8();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule